// File: doc/BRIEF.md
# Checksum-Guarded Management Register Port

This block is the device-side front end of a small register bank reached over a Clause 22 style management bus. A plain synchronous request interface stands in for the serial frame layer. Each request carries a 5-bit PHY field, a 5-bit register field, a write flag and 16 bits of write data. The two fields join into a 10-bit absolute address, PHY field in the upper five bits. Reads return their data one cycle later.

A service PHY address holds two special registers: a control register that switches error checking on, and a check register that carries an 8-bit checksum and a sticky mismatch flag. With checking on, a data write is not applied at once. It is parked as pending and applied only when the host writes the matching checksum into the check register. After each read, the device loads the checksum of that read into the check register, so the host can compare it with its own result. The checksum is an XOR fold of the data, the absolute address and the 2-bit bus opcode.

Top module: `mgmt_csum_port`

## Requirements
- R1: Checksum bit i (0..7) is data[i]^data[i+8]^addr[i]; bits 0 and 1 also XOR in addr[i+8], bits 2 and 3 also XOR in op[i-2]; the opcode is 2'b01 for a write and 2'b10 for a read.
- R2: The absolute address is {phy[4:0], reg[4:0]}; absolute addresses 0..DEPTH-1 (default 64) are storage words that reset to 0; other non-service addresses read 0 and ignore writes.
- R3: The control register (PHY 0x19, register 0x1A) reads as {15'b0, enable}, is written directly in either mode, and clearing enable drops any pending write; while enable is 0, writes to the check register have no effect.
- R4: With enable 0, a data write is applied at the clock edge that takes it and is visible to the next read.
- R5: With enable 1, a data write is held and becomes visible only after a check-register write whose bits [7:0] equal the write checksum (opcode 2'b01) of the held data and address.
- R6: A check-register write (PHY 0x19, register 0x19) that does not match, or that arrives with nothing held, discards the held write and sets the mismatch flag; the check register reads as {7'b0, mismatch, byte[7:0]}.
- R7: The mismatch flag clears on the next data write taken with enable 1, or on a matching check write.
- R8: A read of any register other than the check register loads byte[7:0] with the read checksum (opcode 2'b10) of the returned data and its absolute address.
- R9: A read of the check register leaves byte[7:0] unchanged.
- R10: rsp_valid pulses for exactly one cycle, one cycle after each read request, and never after a write.
- R11: After reset, enable, the mismatch flag, the checksum byte and all storage words are 0.
- R12: A second data write taken while one is held replaces it; only the newest held write can be applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address field |
| req_reg | input | 5 | Register address field |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 16 | Read data |

## Verification
The guarded write path is driven with a matching checksum, a checksum with one bit flipped, a checksum that follows two back-to-back held writes, and a check write sent after checking was turned off. These show a commit apart from a discard, and the newest held write apart from a stale one. Read checksums are fetched after reads of a low storage word and of the control register, whose absolute address sets bits 8 and 9. This checks the upper-address and opcode terms, which a low address alone cannot reach. Storage words under two PHY fields and one address out of range show that the address concatenation and the range limit are right.

// File: rtl/mgmt_csum_pkg.sv
// Shared widths, bus opcodes and service register addresses for the
// checksum-guarded management port.
package mgmt_csum_pkg;
    localparam int DATA_W = 16;
    localparam int FLD_W  = 5;
    localparam int ABS_W  = 2 * FLD_W;
    localparam int SUM_W  = 8;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    localparam logic [FLD_W-1:0] SVC_PHY = 5'h19;
    localparam logic [FLD_W-1:0] CHK_REG = 5'h19;
    localparam logic [FLD_W-1:0] CTL_REG = 5'h1A;

    localparam logic [ABS_W-1:0] CHK_ABS = {SVC_PHY, CHK_REG};
    localparam logic [ABS_W-1:0] CTL_ABS = {SVC_PHY, CTL_REG};

    typedef logic [ABS_W-1:0]  abs_addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SUM_W-1:0]  sum_t;
endpackage

// File: rtl/mgmt_csum_calc.sv
// XOR-fold checksum over 16-bit data, 10-bit absolute address and 2-bit
// opcode. Purely combinational; assumes the fixed widths of the package.
module mgmt_csum_calc
    import mgmt_csum_pkg::*;
(
    input  word_t     data,
    input  abs_addr_t addr,
    input  logic [1:0] op,
    output sum_t      sum
);
    genvar i;
    generate
        for (i = 0; i < SUM_W; i++) begin : g_bit
            // Each bit folds the two data halves with the low address bit,
            // then adds an upper-address or opcode term for the low four bits.
            if (i < 2) begin : g_hiaddr
                assign sum[i] = data[i] ^ data[i+8] ^ addr[i] ^ addr[i+8];
            end else if (i < 4) begin : g_op
                assign sum[i] = data[i] ^ data[i+8] ^ addr[i] ^ op[i-2];
            end else begin : g_plain
                assign sum[i] = data[i] ^ data[i+8] ^ addr[i];
            end
        end
    endgenerate
endmodule

// File: rtl/mgmt_regbank.sv
// Storage words at absolute addresses 0..DEPTH-1. Writes outside the range
// are dropped, reads outside it return zero. Read is combinational.
module mgmt_regbank
    import mgmt_csum_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  abs_addr_t waddr,
    input  word_t     wdata,
    input  abs_addr_t raddr,
    output word_t     rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t words [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            word_t q;
            // Per-word storage: load on a write addressed to this entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && (int'(waddr) == g))
                    q <= wdata;
            end
            assign words[g] = q;
        end
    endgenerate

    logic [IDX_W-1:0] ridx;
    assign ridx = IDX_W'(raddr);

    // Read mux with out-of-range addresses returning zero.
    always_comb begin
        if (int'(raddr) < DEPTH)
            rdata = words[ridx];
        else
            rdata = '0;
    end
endmodule

// File: rtl/mgmt_guard.sv
// Holds guarded writes, compares the host checksum and keeps the enable,
// mismatch and checksum-byte state. Assumes at most one request per cycle
// and that the caller decodes the two service addresses.
module mgmt_guard
    import mgmt_csum_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_write,
    input  logic      req_is_ctl,
    input  logic      req_is_chk,
    input  abs_addr_t req_abs,
    input  word_t     req_wdata,
    input  sum_t      rd_sum,
    input  sum_t      pend_sum,
    output logic      rf_we,
    output abs_addr_t rf_waddr,
    output word_t     rf_wdata,
    output logic      chk_en,
    output logic      chk_err,
    output sum_t      chk_byte,
    output abs_addr_t pend_addr,
    output word_t     pend_data
);
    logic pend_valid;
    logic wr, rd, is_data, sum_ok;

    assign wr      = req_valid && req_write;
    assign rd      = req_valid && !req_write;
    assign is_data = !req_is_ctl && !req_is_chk;
    assign sum_ok  = pend_valid && (req_wdata[SUM_W-1:0] == pend_sum);

    // Storage write port: direct writes when unguarded, held writes on a match.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = req_abs;
        rf_wdata = req_wdata;
        if (wr && is_data && !chk_en) begin
            rf_we = 1'b1;
        end else if (wr && req_is_chk && chk_en && sum_ok) begin
            rf_we    = 1'b1;
            rf_waddr = pend_addr;
            rf_wdata = pend_data;
        end
    end

    // Guard state: enable, held write, mismatch flag and checksum byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_en     <= 1'b0;
            chk_err    <= 1'b0;
            chk_byte   <= '0;
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else begin
            if (wr && req_is_ctl) begin
                chk_en <= req_wdata[0];
                if (!req_wdata[0])
                    pend_valid <= 1'b0;
            end
            if (wr && is_data && chk_en) begin
                pend_valid <= 1'b1;
                pend_addr  <= req_abs;
                pend_data  <= req_wdata;
                chk_err    <= 1'b0;
            end
            if (wr && req_is_chk && chk_en) begin
                chk_byte   <= req_wdata[SUM_W-1:0];
                pend_valid <= 1'b0;
                chk_err    <= !sum_ok;
            end
            if (rd && !req_is_chk)
                chk_byte <= rd_sum;
        end
    end
endmodule

// File: rtl/mgmt_csum_port.sv
// Top of the checksum-guarded management port. Decodes the request address,
// muxes read data from storage and the service registers, and registers the
// read response. Assumes one request per cycle on a simple strobe interface.
module mgmt_csum_port
    import mgmt_csum_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata
);
    abs_addr_t req_abs;
    logic      is_ctl, is_chk;
    logic      rf_we;
    abs_addr_t rf_waddr;
    word_t     rf_wdata, rf_rdata;
    logic      chk_en, chk_err;
    sum_t      chk_byte, rd_sum, pend_sum;
    abs_addr_t pend_addr;
    word_t     pend_data;
    word_t     rd_val;

    assign req_abs = {req_phy, req_reg};
    assign is_ctl  = (req_abs == CTL_ABS);
    assign is_chk  = (req_abs == CHK_ABS);

    mgmt_regbank #(.DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (req_abs),
        .rdata (rf_rdata)
    );

    mgmt_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_is_ctl (is_ctl),
        .req_is_chk (is_chk),
        .req_abs    (req_abs),
        .req_wdata  (req_wdata),
        .rd_sum     (rd_sum),
        .pend_sum   (pend_sum),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .chk_en     (chk_en),
        .chk_err    (chk_err),
        .chk_byte   (chk_byte),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data)
    );

    // Read data selection across the service registers and storage.
    always_comb begin
        if (is_ctl)
            rd_val = {{(DATA_W-1){1'b0}}, chk_en};
        else if (is_chk)
            rd_val = {{(DATA_W-SUM_W-1){1'b0}}, chk_err, chk_byte};
        else
            rd_val = rf_rdata;
    end

    mgmt_csum_calc u_rd_sum (
        .data (rd_val),
        .addr (req_abs),
        .op   (OP_RD),
        .sum  (rd_sum)
    );

    mgmt_csum_calc u_wr_sum (
        .data (pend_data),
        .addr (pend_addr),
        .op   (OP_WR),
        .sum  (pend_sum)
    );

    // Registered read response; data holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/mgmt_csum_port_chk.sv
// Property checker for mgmt_csum_port, attached by bind. Observes ports and
// the state and write strobe that the guard hands to the storage bank.
module mgmt_csum_port_chk
    import mgmt_csum_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic [4:0] req_phy,
    input logic [4:0] req_reg,
    input logic       rsp_valid,
    input logic       chk_en,
    input logic       chk_err,
    input sum_t       chk_byte,
    input logic       rf_we
);
    logic a_ctl, a_chk, a_data, a_rd, a_wr;
    assign a_ctl  = ({req_phy, req_reg} == CTL_ABS);
    assign a_chk  = ({req_phy, req_reg} == CHK_ABS);
    assign a_data = !a_ctl && !a_chk;
    assign a_rd   = req_valid && !req_write;
    assign a_wr   = req_valid && req_write;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd |=> rsp_valid); // R10
    AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rd |=> !rsp_valid); // R10
    AST_UNGUARDED_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_data && !chk_en) |-> rf_we); // R4
    AST_GUARDED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_data && chk_en) |-> !rf_we); // R5
    AST_ERR_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_data && chk_en) |=> !chk_err); // R7
    AST_MISMATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_chk && chk_en && !rf_we) |=> chk_err); // R6
    AST_CHK_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd && a_chk) |=> $stable(chk_byte)); // R9
    AST_CHK_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_chk && !chk_en) |=> ($stable(chk_byte) && $stable(chk_err))); // R3
endmodule

bind mgmt_csum_port mgmt_csum_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .rsp_valid (rsp_valid),
    .chk_en    (chk_en),
    .chk_err   (chk_err),
    .chk_byte  (chk_byte),
    .rf_we     (rf_we)
);

// File: tb/sim_mgmt_csum_port.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them as responses appear.
module sim_mgmt_csum_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mgmt_csum_port u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] fold(input logic [15:0] d, input logic [9:0] a,
                                        input logic [1:0] op);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) begin
            s[i] = d[i] ^ d[i+8] ^ a[i];
            if (i == 0 || i == 1) s[i] = s[i] ^ a[i+8];
            if (i == 2 || i == 3) s[i] = s[i] ^ op[i-2];
        end
        return s;
    endfunction

    function automatic logic [9:0] ab(input logic [4:0] p, input logic [4:0] r);
        return {p, r};
    endfunction

    task automatic wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_phy = p; req_reg = r; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] p, input logic [4:0] r, input logic [15:0] e,
                      input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = p; req_reg = r;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected response act=%h exp=none", rsp_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", t, rsp_rdata, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [4:0] SP = 5'h19, CK = 5'h19, CT = 5'h1A;

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state of service registers and storage
        rd(SP, CK, 16'h0000, "R11 check reg after reset");
        rd(SP, CT, 16'h0000, "R11 control after reset");
        rd(5'd0, 5'd3, 16'h0000, "R11 storage after reset");

        // R4: unguarded write is visible to the next read
        wr(5'd0, 5'd3, 16'h1234);
        rd(5'd0, 5'd3, 16'h1234, "R4 direct write");
        // R8: read checksum loaded into the check register
        rd(SP, CK, {8'h00, fold(16'h1234, ab(0, 3), 2'b10)}, "R8 read checksum low addr");

        // R10: no response after a write
        wr(5'd1, 5'd2, 16'hBEEF);
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R10 rsp after write act=%b exp=0", rsp_valid);
        end

        // R2: address concatenation and range limit
        rd(5'd1, 5'd2, 16'hBEEF, "R2 phy1 word");
        rd(5'd0, 5'd2, 16'h0000, "R2 phy0 word distinct");
        wr(5'd3, 5'd0, 16'h5555);
        rd(5'd3, 5'd0, 16'h0000, "R2 out of range reads zero");

        // R3: enable checking
        wr(SP, CT, 16'h0001);
        rd(SP, CT, 16'h0001, "R3 control readback");
        // R1: checksum with address bits 8 and 9 set
        rd(SP, CK, {8'h00, fold(16'h0001, ab(SP, CT), 2'b10)}, "R1 read checksum high addr");

        // R5: held write, then matching checksum
        wr(5'd0, 5'd7, 16'hA5C3);
        rd(5'd0, 5'd7, 16'h0000, "R5 held write not visible");
        wr(SP, CK, {8'h00, fold(16'hA5C3, ab(0, 7), 2'b01)});
        rd(5'd0, 5'd7, 16'hA5C3, "R5 committed after match");
        s = fold(16'hA5C3, ab(0, 7), 2'b10);
        rd(SP, CK, {8'h00, s}, "R7 match leaves flag clear");

        // R6: wrong checksum discards the held write
        wr(5'd0, 5'd7, 16'h0F0F);
        wr(SP, CK, {8'h00, fold(16'h0F0F, ab(0, 7), 2'b01) ^ 8'h01});
        rd(5'd0, 5'd7, 16'hA5C3, "R6 mismatch discards");
        rd(SP, CK, {7'b0, 1'b1, s}, "R6 mismatch flag set");
        // R9: check-register read left the byte alone; R7: data write clears flag
        wr(5'd0, 5'd8, 16'h1111);
        rd(SP, CK, {8'h00, s}, "R7 R9 flag cleared byte kept");
        wr(SP, CK, {8'h00, fold(16'h1111, ab(0, 8), 2'b01)});
        rd(5'd0, 5'd8, 16'h1111, "R5 second commit");

        // R6: check write with nothing held
        wr(SP, CK, 16'h0042);
        rd(SP, CK, 16'h0142, "R6 no held write");

        // R12: newer held write replaces older one
        wr(5'd0, 5'd10, 16'h3333);
        wr(5'd0, 5'd11, 16'h4444);
        wr(SP, CK, {8'h00, fold(16'h4444, ab(0, 11), 2'b01)});
        rd(5'd0, 5'd11, 16'h4444, "R12 newest commits");
        rd(5'd0, 5'd10, 16'h0000, "R12 older dropped");

        // R3: disabling drops the held write and ignores check writes
        wr(5'd0, 5'd12, 16'h7777);
        wr(SP, CT, 16'h0000);
        rd(5'd0, 5'd12, 16'h0000, "R3 disable drops held write");
        s = fold(16'h0000, ab(0, 12), 2'b10);
        wr(SP, CK, 16'h00AB);
        rd(SP, CK, {8'h00, s}, "R3 check write ignored when off");
        wr(5'd0, 5'd12, 16'h7777);
        rd(5'd0, 5'd12, 16'h7777, "R4 direct after disable");

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R10 missing responses act=%0d exp=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule